// File: doc/BRIEF.md
# E3 G.832 Transmit Frame Timing Generator

This block is the frame-master timing core of a serial E3 transmit path that uses the G.832 frame structure. It runs on the local transmit clock. A free-running position counter alone decides where each frame starts. On every clock it puts out one serial bit. That bit is either overhead that the block builds itself, or a payload bit taken from an upstream source.

The upstream source is paced only by the overhead indicator. The indicator is high for every bit-period that carries overhead. After each rising edge, the source looks at the indicator. If the indicator is low, the bit it was holding has just been sent, so it presents the next one. If the indicator is high, it keeps holding its bit. A one-clock frame pulse marks the first framing bit of every frame.

The two framing bytes are fixed by parameters. The five other overhead bytes come from a register input, which is captured once per frame. The byte positions of those five bytes within the frame are also set by parameters.

Top module: `e3g832_tx_timing`

## Requirements
- R1: A frame lasts 4296 clocks (537 bytes). `tx_frm` is high for exactly one clock per frame, and two consecutive pulses are 4296 clocks apart.
- R2: While `rst` is high, `tx_ser`, `tx_oh` and `tx_frm` read 0. In the first clock after `rst` falls, `tx_frm` is 1 and `tx_ser` carries the first framing bit.
- R3: The first 16 bits of a frame are the framing bytes, 0xF6 then 0x28, each sent most significant bit first. `tx_oh` stays high for all 16 of these clocks, and this run is the first overhead run of the frame.
- R4: Each of the five other overhead bytes raises `tx_oh` for exactly 8 consecutive clocks. Slot i occupies frame byte `AUX_AT[i]`, with defaults 59, 118, 236, 354 and 472, and is sent most significant bit first.
- R5: In every frame, `tx_oh` is low in exactly 4240 clocks.
- R6: In any clock where `tx_oh` is low, `tx_ser` equals the value of `tx_pay_bit` sampled at the rising edge that started that clock.
- R7: Overhead slot i is taken from `tx_aux_oh[8*i+7:8*i]`. The input is captured at the rising edge that emits the first bit of a frame. A change made at any other time does not appear until the next frame.
- R8: The value of `tx_pay_bit` never affects `tx_ser` in a clock where `tx_oh` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local transmit clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_pay_bit | input | 1 | Payload bit held by the upstream source |
| tx_aux_oh | input | 40 | Five overhead bytes; slot i is in bits 8i+7..8i |
| tx_ser | output | 1 | Serial E3 frame stream, registered |
| tx_frm | output | 1 | One-clock frame start pulse, aligned with the first framing bit |
| tx_oh | output | 1 | High while the current bit is overhead |

## Verification
The riskiest points are the wrap from the last payload bit straight into the first framing bit, and the first frame after a reset. A counter that is off by one there gives a frame period of 4295 or 4297 clocks, and the payload count shifts with it. A second target is the handshake at each boundary between overhead and payload. Here the bench source advances only after it sees the indicator low. A design whose indicator is one clock early or late would either drop payload bits or send one twice. Some frames hold the payload input at all ones or all zeros while the overhead bytes have the opposite value, which exposes payload leaking into overhead positions. Other frames change the overhead register in mid-frame and in the last clock before the wrap, which catches a design that captures the register at the wrong edge or keeps following it during the frame.

// File: rtl/e3tx_pkg.sv
package e3tx_pkg;

  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned N_AUX   = 5;
  localparam int unsigned N_SLOT  = N_AUX + 2;
  localparam int unsigned SLOT_W  = $clog2(N_SLOT);
  localparam int unsigned POS_W   = 16;

  // Result of mapping a frame byte index onto the overhead layout.
  typedef struct packed {
    logic              is_oh;
    logic [SLOT_W-1:0] slot;
  } oh_sel_t;

endpackage

// File: rtl/e3tx_pos_cnt.sv
module e3tx_pos_cnt #(
  parameter int unsigned FRAME_BYTES = 537,
  parameter int unsigned BYTE_IDX_W  = $clog2(FRAME_BYTES)
) (
  input  logic                  clk,
  input  logic                  rst,
  output logic [BYTE_IDX_W-1:0] byte_idx,
  output logic [2:0]            bit_idx,
  output logic                  frame_start
);

  localparam logic [BYTE_IDX_W-1:0] LAST_BYTE = BYTE_IDX_W'(FRAME_BYTES - 1);

  logic [BYTE_IDX_W-1:0] byte_q;
  logic [2:0]            bit_q;

  // Position of the bit that the next clock edge emits.
  always_ff @(posedge clk) begin
    if (rst) begin
      byte_q <= '0;
      bit_q  <= '0;
    end else begin
      bit_q <= bit_q + 3'd1;
      if (bit_q == 3'd7) begin
        if (byte_q == LAST_BYTE) begin
          byte_q <= '0;
        end else begin
          byte_q <= byte_q + 1'b1;
        end
      end
    end
  end

  assign byte_idx    = byte_q;
  assign bit_idx     = bit_q;
  assign frame_start = (byte_q == '0) && (bit_q == 3'd0);

endmodule

// File: rtl/e3tx_oh_map.sv
module e3tx_oh_map
  import e3tx_pkg::*;
#(
  parameter int unsigned BYTE_IDX_W = 10,
  parameter logic [N_AUX*POS_W-1:0] AUX_AT = {16'd472, 16'd354, 16'd236, 16'd118, 16'd59}
) (
  input  logic [BYTE_IDX_W-1:0] byte_idx,
  output oh_sel_t               sel
);

  logic [N_AUX-1:0] aux_hit;

  for (genvar gi = 0; gi < N_AUX; gi++) begin : g_hit
    localparam logic [BYTE_IDX_W-1:0] AT_I = AUX_AT[gi*POS_W +: BYTE_IDX_W];
    assign aux_hit[gi] = (byte_idx == AT_I);
  end

  always_comb begin
    sel.is_oh = 1'b0;
    sel.slot  = '0;
    if (byte_idx == BYTE_IDX_W'(0)) begin
      sel.is_oh = 1'b1;
      sel.slot  = SLOT_W'(0);
    end else if (byte_idx == BYTE_IDX_W'(1)) begin
      sel.is_oh = 1'b1;
      sel.slot  = SLOT_W'(1);
    end else begin
      for (int i = 0; i < N_AUX; i++) begin
        if (aux_hit[i]) begin
          sel.is_oh = 1'b1;
          sel.slot  = SLOT_W'(i + 2);
        end
      end
    end
  end

endmodule

// File: rtl/e3tx_oh_bank.sv
module e3tx_oh_bank
  import e3tx_pkg::*;
#(
  parameter logic [BYTE_W-1:0] FA1 = 8'hF6,
  parameter logic [BYTE_W-1:0] FA2 = 8'h28
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic [N_AUX*BYTE_W-1:0] aux_in,
  input  logic [SLOT_W-1:0]       slot,
  input  logic [2:0]              bit_idx,
  output logic                    oh_bit
);

  logic [N_AUX*BYTE_W-1:0] aux_q;
  logic [BYTE_W-1:0]       slot_byte [N_SLOT];
  logic [BYTE_W-1:0]       cur_byte;

  // Captured once per frame so a frame never mixes two register settings.
  always_ff @(posedge clk) begin
    if (rst) begin
      aux_q <= '0;
    end else if (load) begin
      aux_q <= aux_in;
    end
  end

  assign slot_byte[0] = FA1;
  assign slot_byte[1] = FA2;
  for (genvar gi = 0; gi < N_AUX; gi++) begin : g_slot
    assign slot_byte[gi+2] = aux_q[gi*BYTE_W +: BYTE_W];
  end

  always_comb begin
    cur_byte = '0;
    for (int i = 0; i < N_SLOT; i++) begin
      if (slot == SLOT_W'(i)) begin
        cur_byte = slot_byte[i];
      end
    end
  end

  assign oh_bit = cur_byte[3'd7 - bit_idx];

endmodule

// File: rtl/e3g832_tx_timing.sv
module e3g832_tx_timing
  import e3tx_pkg::*;
#(
  parameter int unsigned FRAME_BYTES = 537,
  parameter logic [BYTE_W-1:0] FA1 = 8'hF6,
  parameter logic [BYTE_W-1:0] FA2 = 8'h28,
  parameter logic [N_AUX*POS_W-1:0] AUX_AT = {16'd472, 16'd354, 16'd236, 16'd118, 16'd59}
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tx_pay_bit,
  input  logic [N_AUX*BYTE_W-1:0] tx_aux_oh,
  output logic                    tx_ser,
  output logic                    tx_frm,
  output logic                    tx_oh
);

  localparam int unsigned BYTE_IDX_W = $clog2(FRAME_BYTES);

  logic [BYTE_IDX_W-1:0] byte_idx;
  logic [2:0]            bit_idx;
  logic                  frame_start;
  oh_sel_t               sel;
  logic                  oh_bit;

  logic ser_q, frm_q, oh_q;

  e3tx_pos_cnt #(
    .FRAME_BYTES (FRAME_BYTES),
    .BYTE_IDX_W  (BYTE_IDX_W)
  ) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .byte_idx    (byte_idx),
    .bit_idx     (bit_idx),
    .frame_start (frame_start)
  );

  e3tx_oh_map #(
    .BYTE_IDX_W (BYTE_IDX_W),
    .AUX_AT     (AUX_AT)
  ) u_map (
    .byte_idx (byte_idx),
    .sel      (sel)
  );

  e3tx_oh_bank #(
    .FA1 (FA1),
    .FA2 (FA2)
  ) u_bank (
    .clk     (clk),
    .rst     (rst),
    .load    (frame_start),
    .aux_in  (tx_aux_oh),
    .slot    (sel.slot),
    .bit_idx (bit_idx),
    .oh_bit  (oh_bit)
  );

  // All three outputs describe the same bit-period.
  always_ff @(posedge clk) begin
    if (rst) begin
      ser_q <= 1'b0;
      frm_q <= 1'b0;
      oh_q  <= 1'b0;
    end else begin
      frm_q <= frame_start;
      oh_q  <= sel.is_oh;
      ser_q <= sel.is_oh ? oh_bit : tx_pay_bit;
    end
  end

  assign tx_ser = ser_q;
  assign tx_frm = frm_q;
  assign tx_oh  = oh_q;

endmodule

// File: rtl/e3tx_chk.sv
module e3tx_chk #(
  parameter int unsigned FRAME_BITS = 4296,
  parameter int unsigned PAY_BITS   = 4240
) (
  input logic clk,
  input logic rst,
  input logic tx_pay_bit,
  input logic tx_ser,
  input logic tx_frm,
  input logic tx_oh
);

  logic [15:0] since_frm;
  logic [15:0] low_cnt;
  logic [4:0]  run_hi;
  logic        seen_frm;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_frm <= '0;
      low_cnt   <= '0;
      run_hi    <= '0;
      seen_frm  <= 1'b0;
    end else begin
      since_frm <= tx_frm ? 16'd1 : since_frm + 16'd1;
      low_cnt   <= tx_frm ? 16'd0 : low_cnt + {15'd0, ~tx_oh};
      run_hi    <= tx_oh ? run_hi + 5'd1 : 5'd0;
      if (tx_frm) seen_frm <= 1'b1;
    end
  end

  // R1
  frm_period_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_frm && seen_frm) |-> (since_frm == 16'(FRAME_BITS)));

  // R2
  rst_quiet_chk: assert property (@(posedge clk)
    rst |=> (!tx_ser && !tx_oh && !tx_frm));

  // R2
  first_frm_chk: assert property (@(posedge clk)
    ($past(rst) && !rst) |=> tx_frm);

  // R3
  frm_on_oh_chk: assert property (@(posedge clk) disable iff (rst)
    tx_frm |-> tx_oh);

  // R4
  oh_run_len_chk: assert property (@(posedge clk) disable iff (rst)
    (!tx_oh && run_hi != 5'd0) |-> (run_hi == 5'd8 || run_hi == 5'd16));

  // R5
  pay_count_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_frm && seen_frm) |-> (low_cnt == 16'(PAY_BITS)));

  // R6
  pay_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (!tx_oh && !$past(rst)) |-> (tx_ser == $past(tx_pay_bit)));

endmodule

bind e3g832_tx_timing e3tx_chk #(
  .FRAME_BITS (FRAME_BYTES * 8),
  .PAY_BITS   ((FRAME_BYTES - 7) * 8)
) u_e3tx_chk (
  .clk        (clk),
  .rst        (rst),
  .tx_pay_bit (tx_pay_bit),
  .tx_ser     (tx_ser),
  .tx_frm     (tx_frm),
  .tx_oh      (tx_oh)
);

// File: tb/tb_e3g832_tx_timing.sv
`timescale 1ns/1ps
module tb_e3g832_tx_timing;

  localparam int FBITS    = 4296;
  localparam int PAYBITS  = 4240;
  localparam int FA1V     = 8'hF6;
  localparam int FA2V     = 8'h28;
  localparam int AT [5]   = '{59, 118, 236, 354, 472};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tx_pay_bit = 1'b0;
  logic [39:0] tx_aux_oh = '0;
  logic        tx_ser, tx_frm, tx_oh;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  int          k;
  logic [39:0] lat;
  int          run_hi, run_idx, low_cnt, since_frm;
  bit          seen_frm;
  int          modes [6] = '{0, 1, 2, 3, 3, 0};

  always #10 clk = ~clk;

  e3g832_tx_timing dut (
    .clk        (clk),
    .rst        (rst),
    .tx_pay_bit (tx_pay_bit),
    .tx_aux_oh  (tx_aux_oh),
    .tx_ser     (tx_ser),
    .tx_frm     (tx_frm),
    .tx_oh      (tx_oh)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at k=%0d: actual %0d expected %0d", tag, k, act, exp);
    end
  endtask

  // Byte value at frame byte b, or -1 for payload.
  function automatic int exp_val(input int b, input logic [39:0] l);
    if (b == 0) return FA1V;
    if (b == 1) return FA2V;
    for (int i = 0; i < 5; i++) begin
      if (b == AT[i]) return int'(l[i*8 +: 8]);
    end
    return -1;
  endfunction

  function automatic logic [39:0] aux_for(input int mode);
    if (mode == 1) return 40'h0;
    if (mode == 2) return 40'hFF_FFFF_FFFF;
    return {8'($urandom), $urandom};
  endfunction

  function automatic logic pay_for(input int mode);
    if (mode == 1) return 1'b1;
    if (mode == 2) return 1'b0;
    return 1'($urandom);
  endfunction

  task automatic clear_stats();
    k = 0; run_hi = 0; run_idx = 0; low_cnt = 0; since_frm = 0; seen_frm = 1'b0;
  endtask

  task automatic step(input int mode, input int next_mode);
    int p, b, bi, ev;
    logic e_oh, e_ser, e_frm;
    @(negedge clk);
    p  = k % FBITS;
    b  = p / 8;
    bi = 7 - (p % 8);
    if (p == 0) lat = tx_aux_oh;
    ev    = exp_val(b, lat);
    e_oh  = (ev >= 0);
    e_ser = e_oh ? ev[bi] : tx_pay_bit;
    e_frm = (p == 0);

    chk(tx_frm === e_frm, (k == 0) ? "R2 first frame pulse" : "R1 frame pulse", tx_frm, e_frm);
    chk(tx_oh === e_oh, (b < 2) ? "R3 framing indicator" : "R4 overhead indicator", tx_oh, e_oh);
    if (!e_oh)
      chk(tx_ser === e_ser, "R6 payload bit", tx_ser, e_ser);
    else if (b < 2)
      chk(tx_ser === e_ser, "R3 framing bit", tx_ser, e_ser);
    else if (mode == 1 || mode == 2)
      chk(tx_ser === e_ser, "R8 overhead isolated from payload", tx_ser, e_ser);
    else
      chk(tx_ser === e_ser, "R7 overhead byte bit", tx_ser, e_ser);

    // Observed frame statistics.
    if (tx_frm) begin
      if (seen_frm) begin
        chk(since_frm == FBITS, "R1 pulse spacing", since_frm, FBITS);
        chk(low_cnt == PAYBITS, "R5 payload clocks per frame", low_cnt, PAYBITS);
      end
      seen_frm  = 1'b1;
      since_frm = 0;
      low_cnt   = 0;
      run_idx   = 0;
    end
    since_frm++;
    if (tx_oh) begin
      run_hi++;
    end else begin
      if (run_hi > 0) begin
        chk(run_hi == ((run_idx == 0) ? 16 : 8),
            (run_idx == 0) ? "R3 framing run" : "R4 overhead run",
            run_hi, (run_idx == 0) ? 16 : 8);
        run_idx++;
      end
      run_hi = 0;
      low_cnt++;
    end

    // Upstream source: advance only after a low indicator.
    if (!tx_oh) tx_pay_bit = pay_for(mode);
    if (mode == 3 && (p == 2000 || p == FBITS - 1)) tx_aux_oh = aux_for(3);
    if (p == FBITS - 1 && next_mode != 3) tx_aux_oh = aux_for(next_mode);
    k++;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    clear_stats();
    tx_aux_oh = aux_for(0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(tx_ser === 1'b0, "R2 reset ser", tx_ser, 0);
    chk(tx_oh  === 1'b0, "R2 reset oh", tx_oh, 0);
    chk(tx_frm === 1'b0, "R2 reset frm", tx_frm, 0);
    rst = 1'b0;

    for (int f = 0; f < 5; f++) begin
      for (int c = 0; c < FBITS; c++) step(modes[f], modes[f+1]);
    end

    // Reset in mid-frame.
    for (int c = 0; c < 1234; c++) step(0, 0);
    @(negedge clk);
    rst = 1'b1;
    tx_pay_bit = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(tx_ser === 1'b0, "R2 mid reset ser", tx_ser, 0);
    chk(tx_oh  === 1'b0, "R2 mid reset oh", tx_oh, 0);
    chk(tx_frm === 1'b0, "R2 mid reset frm", tx_frm, 0);
    tx_aux_oh = aux_for(0);
    rst = 1'b0;
    clear_stats();
    for (int c = 0; c < FBITS + 40; c++) step(0, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule